// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block is the per-transfer datapath of one DMA channel. Software programs a page value, a start offset and a transfer count. For every transfer the channel performs, the block supplies the physical memory address and a flag that shows whether the transfer is a byte or a 16-bit word. After each acknowledged transfer it moves to the next address and lowers the remaining count. It pulses a terminal-count signal on the last transfer of a block. Arbitration and bus-cycle timing sit outside this block.

Two address layouts are supported. In byte layout the page register supplies the top bits and the offset counter supplies the low bits. In word layout the offset counter is shifted up one position under the page register. Page bit 0 is then unused and address bit 0 is always zero. The page register never counts, so a block of transfers stays inside one 64K-byte window in byte layout or one 128K-byte window in word layout. In either layout the offset and the count are in units of the transfer size.

Two behaviours are possible at the end of a block. With automatic reload enabled, the terminal transfer restores the start offset and the count that were last written. Without it, the channel sets a sticky finished flag and ignores further transfer pulses until software writes the offset or the count again.

Top module: `dma_addr_gen`

## Requirements
- R1: In byte layout (`word_mode`=0), `phys_addr` equals the page register in the top PAGE_W bits, followed by the current offset in the low OFS_W bits.
- R2: In word layout (`word_mode`=1), `phys_addr` is formed from the top to the bottom as page bits [PAGE_W-1:1], then the current offset, then a constant 0. Page bit 0 has no effect.
- R3: Each accepted transfer raises the current offset by one, modulo 2^OFS_W. The page field of `phys_addr` never changes because of a transfer.
- R4: The count written is the number of transfers minus one. `tc_pulse` is high for one cycle after the accepted transfer during which the current count was 0, and it is low after every other transfer.
- R5: With `autoinit`=1, the terminal transfer reloads the current offset and count from the last written values, and `chan_done` stays 0.
- R6: With `autoinit`=0, the terminal transfer sets `chan_done`. While `chan_done` is 1, transfer pulses leave `phys_addr` unchanged and produce no `tc_pulse`.
- R7: Writing the offset or the count clears `chan_done`. A transfer pulse in the same cycle as any register write is dropped, and the written value appears on `phys_addr`.
- R8: `tc_pulse` and `chan_done` update at the clock edge that samples the transfer pulse. `phys_addr` follows one cycle later.
- R9: After reset, `phys_addr`, `word_xfer`, `tc_pulse` and `chan_done` are all 0.
- R10: `word_xfer` shows `word_mode` one cycle after it is sampled, with 1 meaning a 16-bit word transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_ld | input | 1 | Write strobe for the page register |
| page_din | input | PAGE_W | Page value |
| addr_ld | input | 1 | Write strobe for the base and current offset |
| addr_din | input | OFS_W | Start offset, in transfer units |
| cnt_ld | input | 1 | Write strobe for the base and current count |
| cnt_din | input | OFS_W | Number of transfers minus one |
| word_mode | input | 1 | 1 selects 16-bit word layout, 0 selects byte layout |
| autoinit | input | 1 | Reload the offset and count on terminal count |
| xfer_done | input | 1 | One-cycle pulse for each acknowledged transfer |
| phys_addr | output | PAGE_W+OFS_W | Registered physical address |
| word_xfer | output | 1 | Registered transfer-size indication |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| chan_done | output | 1 | Sticky finished flag when reload is disabled |

## Verification
The bench builds the block with PAGE_W=4 and OFS_W=4, which gives an 8-bit address and a 16-entry offset ring. At that size the bench can cover every page value and every start offset in both layouts. Each run goes once all the way round the offset ring and then one transfer further, so the wrap point, the terminal pulse and the reload all occur in every run. Every count value from 0 to 15 is also run with reload disabled, which shows exactly where the terminal pulse falls, that the channel stays frozen after it and that a new count write releases it.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_size_e;
endpackage

// File: rtl/dma_ag_chan.sv
module dma_ag_chan #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_ld,
  input  logic [OFS_W-1:0] addr_din,
  input  logic             cnt_ld,
  input  logic [OFS_W-1:0] cnt_din,
  input  logic             any_ld,
  input  logic             autoinit,
  input  logic             xfer_done,
  output logic [OFS_W-1:0] cur_addr,
  output logic             tc_q,
  output logic             done_q
);
  localparam logic [OFS_W-1:0] CNT_ZERO = '0;

  logic [OFS_W-1:0] base_addr, base_cnt, cur_cnt;
  logic             step, last;

  // A transfer counts only when the channel is live and no write is pending.
  assign step = xfer_done && !done_q && !any_ld;
  assign last = (cur_cnt == CNT_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      tc_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (addr_ld) begin
        base_addr <= addr_din;
        cur_addr  <= addr_din;
      end
      if (cnt_ld) begin
        base_cnt <= cnt_din;
        cur_cnt  <= cnt_din;
      end
      if (addr_ld || cnt_ld) done_q <= 1'b0;
      if (step) begin
        tc_q <= last;
        if (last && autoinit) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
          if (last) done_q <= 1'b1;
        end
      end
    end
  end

  AST_TC_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> ($past(cur_cnt) == CNT_ZERO) && $past(xfer_done)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_q && !addr_ld && !cnt_ld |=> done_q); // R6
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    done_q && !addr_ld && !cnt_ld |=> $stable(cur_addr) && !tc_q); // R6
  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (rst)
    tc_q && $past(autoinit) && !$past(any_ld) |-> cur_addr == base_addr && !done_q); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    addr_ld |=> cur_addr == $past(addr_din)); // R7
endmodule

// File: rtl/dma_ag_map.sv
module dma_ag_map
  import dma_ag_pkg::*;
#(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    page_ld,
  input  logic [PAGE_W-1:0]       page_din,
  input  logic                    word_mode,
  input  logic [OFS_W-1:0]        cur_addr,
  output logic [PAGE_W+OFS_W-1:0] phys_addr,
  output logic                    word_xfer
);
  localparam int AW = PAGE_W + OFS_W;

  logic [PAGE_W-1:0] page_q;
  logic [AW-1:0]     addr_nx;
  xfer_size_e        size;

  assign size = word_mode ? XFER_WORD : XFER_BYTE;

  always_comb begin
    if (size == XFER_WORD) addr_nx = {page_q[PAGE_W-1:1], cur_addr, 1'b0};
    else                   addr_nx = {page_q, cur_addr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      phys_addr <= '0;
      word_xfer <= 1'b0;
    end else begin
      if (page_ld) page_q <= page_din;
      phys_addr <= addr_nx;
      word_xfer <= (size == XFER_WORD);
    end
  end

  AST_WORD_A0_LOW: assert property (@(posedge clk) disable iff (rst)
    word_xfer |-> !phys_addr[0]); // R2
  AST_PAGE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    !$past(page_ld) && !$past(page_ld, 2) && $stable(word_xfer)
    |-> phys_addr[AW-1:OFS_W+1] == $past(phys_addr[AW-1:OFS_W+1])); // R3
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    page_ld,
  input  logic [PAGE_W-1:0]       page_din,
  input  logic                    addr_ld,
  input  logic [OFS_W-1:0]        addr_din,
  input  logic                    cnt_ld,
  input  logic [OFS_W-1:0]        cnt_din,
  input  logic                    word_mode,
  input  logic                    autoinit,
  input  logic                    xfer_done,
  output logic [PAGE_W+OFS_W-1:0] phys_addr,
  output logic                    word_xfer,
  output logic                    tc_pulse,
  output logic                    chan_done
);
  logic [OFS_W-1:0] cur_addr;
  logic             any_ld;

  assign any_ld = page_ld || addr_ld || cnt_ld;

  dma_ag_chan #(.OFS_W(OFS_W)) i_chan (
    .clk(clk), .rst(rst),
    .addr_ld(addr_ld), .addr_din(addr_din),
    .cnt_ld(cnt_ld), .cnt_din(cnt_din),
    .any_ld(any_ld), .autoinit(autoinit), .xfer_done(xfer_done),
    .cur_addr(cur_addr), .tc_q(tc_pulse), .done_q(chan_done)
  );

  dma_ag_map #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) i_map (
    .clk(clk), .rst(rst),
    .page_ld(page_ld), .page_din(page_din),
    .word_mode(word_mode), .cur_addr(cur_addr),
    .phys_addr(phys_addr), .word_xfer(word_xfer)
  );

  AST_TC_SINGLE_SRC: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |-> !$past(any_ld)); // R7
endmodule

// File: tb/test_dma_addr_gen.sv
module test_dma_addr_gen;
  localparam int PW = 4;
  localparam int OW = 4;
  localparam int AW = PW + OW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic page_ld = 0, addr_ld = 0, cnt_ld = 0, word_mode = 0, autoinit = 0, xfer_done = 0;
  logic [PW-1:0] page_din = '0;
  logic [OW-1:0] addr_din = '0, cnt_din = '0;
  logic [AW-1:0] phys_addr;
  logic word_xfer, tc_pulse, chan_done;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // model state
  int m_w, m_ai, m_pg, m_a, m_c, m_ba, m_bc, m_done;

  always #4 clk = ~clk;

  dma_addr_gen #(.PAGE_W(PW), .OFS_W(OW)) i_dma_addr_gen (
    .clk(clk), .rst(rst), .page_ld(page_ld), .page_din(page_din),
    .addr_ld(addr_ld), .addr_din(addr_din), .cnt_ld(cnt_ld), .cnt_din(cnt_din),
    .word_mode(word_mode), .autoinit(autoinit), .xfer_done(xfer_done),
    .phys_addr(phys_addr), .word_xfer(word_xfer), .tc_pulse(tc_pulse),
    .chan_done(chan_done)
  );

  function automatic int exp_phys(int w, int pg, int a);
    if (w != 0) return ((pg >> 1) << (OW + 1)) | ((a % (1 << OW)) << 1);
    return (pg << OW) | (a % (1 << OW));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_all(input int w, input int ai, input int pg, input int st, input int c);
    @(negedge clk);
    word_mode = w[0]; autoinit = ai[0];
    page_ld = 1; page_din = pg[PW-1:0];
    addr_ld = 1; addr_din = st[OW-1:0];
    cnt_ld = 1;  cnt_din = c[OW-1:0];
    @(negedge clk);
    page_ld = 0; addr_ld = 0; cnt_ld = 0;
    @(negedge clk);
    m_w = w; m_ai = ai; m_pg = pg; m_a = st; m_ba = st; m_c = c; m_bc = c; m_done = 0;
  endtask

  task automatic pulse(input bit full);
    int e_tc, old_p, e_p;
    old_p = exp_phys(m_w, m_pg, m_a);
    e_tc = 0;
    if (m_done == 0) begin
      e_tc = (m_c == 0);
      if (m_c == 0 && m_ai != 0) begin
        m_a = m_ba; m_c = m_bc;
      end else begin
        m_a = (m_a + 1) % (1 << OW);
        m_c = (m_c + (1 << OW) - 1) % (1 << OW);
        if (e_tc != 0) m_done = 1;
      end
    end
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    chk(tc_pulse == e_tc[0], (m_ai != 0) ? "R5 tc" : "R4 tc", tc_pulse, e_tc);
    chk(chan_done == m_done[0], "R6 done", chan_done, m_done);
    if (full) chk(phys_addr == old_p[AW-1:0], "R8 phys lag", phys_addr, old_p);
    @(negedge clk);
    e_p = exp_phys(m_w, m_pg, m_a);
    chk(phys_addr == e_p[AW-1:0], (m_w != 0) ? "R2 phys" : "R1 phys", phys_addr, e_p);
    chk(tc_pulse == 1'b0, "R4 tc width", tc_pulse, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    chk(phys_addr == '0, "R9 phys", phys_addr, 0);
    chk(word_xfer == 1'b0, "R9 word", word_xfer, 0);
    chk(tc_pulse == 1'b0, "R9 tc", tc_pulse, 0);
    chk(chan_done == 1'b0, "R9 done", chan_done, 0);

    // R1 R2 R3 R5: all pages, all starts, both layouts, one lap plus reload
    for (int w = 0; w < 2; w++)
      for (int pg = 0; pg < (1 << PW); pg++)
        for (int st = 0; st < (1 << OW); st++) begin
          load_all(w, 1, pg, st, (1 << OW) - 1);
          e = exp_phys(w, pg, st);
          chk(phys_addr == e[AW-1:0], "R3 start", phys_addr, e);
          chk(word_xfer == w[0], "R10 size", word_xfer, w);
          for (int k = 0; k <= (1 << OW); k++) pulse(k == 0);
        end

    // R4 R6 R7: every count without reload
    for (int c = 0; c < (1 << OW); c++) begin
      load_all(c % 2, 0, 9, 3 * c, c);
      for (int k = 0; k <= c; k++) pulse(1'b0);
      pulse(1'b1); // R6 ignored while done
      @(negedge clk); cnt_ld = 1; cnt_din = 1;
      @(negedge clk); cnt_ld = 0;
      chk(chan_done == 1'b0, "R7 done clear", chan_done, 0);
      m_c = 1; m_bc = 1; m_done = 0;
      @(negedge clk);
      pulse(1'b0);
      pulse(1'b0);
    end

    // R7 write wins over a same-cycle transfer
    load_all(0, 0, 2, 5, 3);
    @(negedge clk); xfer_done = 1; addr_ld = 1; addr_din = 9;
    @(negedge clk); xfer_done = 0; addr_ld = 0;
    chk(tc_pulse == 1'b0, "R7 tc", tc_pulse, 0);
    @(negedge clk);
    e = exp_phys(0, 2, 9);
    chk(phys_addr == e[AW-1:0], "R7 phys", phys_addr, e);
    m_a = 9; m_ba = 9;
    pulse(1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule